// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block retunes one clock PLL to a new output frequency from a 25 MHz reference. A client pulses a request together with the wanted output rate in MHz. The block looks that rate up in a built-in table of divider settings. Each entry holds a feedback multiplier M, an input divider N, a post divider P and a 32-bit extended-parameter word. The nominal output is 25 MHz × (M+1)/(N+1)/(P+1). When the bypass bit is set, the PLL passes the reference straight through.

If the rate has an entry, the block runs a fixed sequence over a small register strobe port. It reads the control register, then writes it back with the PLL held powered down and in reset. Next it writes the extended register and waits a programmed settle time. It then writes the control register again with the PLL released, and polls the lock flag in bit 31 of the extended register. Lock raises a one-cycle done pulse. A rate that has no entry, or a lock that does not arrive in time, raises a one-cycle error pulse instead.

The register port has a write strobe, a read strobe, a one-bit register select, write data and read data. Read data must be valid in the same cycle as the read strobe.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, reg_wr_o and reg_rd_o are all 0.
- R2: The table maps 400 MHz to M=95 N=2 P=1 ext=0x31, 200 MHz to M=127 N=0 P=15 ext=0x3F, 334 MHz to M=667 N=4 P=9 ext=0x14D, 1000 MHz to M=119 N=2 P=0 ext=0x3D, and 50 MHz to M=95 N=2 P=15 ext=0x31.
- R3: A request for a rate with no table entry causes no register access. It pulses err_o for one cycle, in the cycle after the request, and busy_o stays 0.
- R4: For a known rate, the control register (reg_sel_o=0) is read in the cycle after the request. The first write to it follows in the next cycle. That write keeps bits [31:26] of the value read, and sets bit 25 (reset)=1, bit 24 (bypass)=0, bit 23 (power-off)=1, P in [22:19], N in [18:13] and M in [12:0].
- R5: The write of the table's ext word to the extended register (reg_sel_o=1) comes in the cycle right after the first control write.
- R6: The second control write comes exactly CYC_PER_US*SETTLE_US+1 cycles after the ext write. It carries the same upper bits and dividers, with bits 25, 24 and 23 all 0.
- R7: After the second write, the extended register is read every cycle. done_o pulses for one cycle, in the cycle after the first read that returns bit 31 = 1.
- R8: If no read returns bit 31 = 1 within LOCK_TMO polling cycles, err_o pulses LOCK_TMO+1 cycles after the second control write, and done_o does not pulse.
- R9: busy_o is 1 from the cycle after an accepted request up to, but not including, the cycle of the done or error pulse. Requests made while busy_o is 1 are ignored: they start no second sequence and change no written value.
- R10: done_o and err_o are single-cycle pulses and are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse, sampled when idle |
| rate_mhz_i | input | RATE_W | Requested output rate in MHz |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: PLL locked |
| err_o | output | 1 | One-cycle pulse: unknown rate or lock timeout |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_sel_o | output | 1 | Register select: 0 control, 1 extended |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid in the cycle reg_rd_o is 1 |

## Verification
Each of the five table rates is requested against a control register whose upper bits and low bits hold non-zero values. This separates correct field packing and preservation of the upper bits from a plain overwrite, and it shows that each entry is distinct. A rate missing from the table separates the error path from a silent start. A lock that never comes exercises the timeout count. A lock that arrives a few cycles after release pins the poll-to-done latency. A second request issued partway through a sequence shows whether the busy guard holds.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int M_W       = 13;
  localparam int N_W       = 6;
  localparam int P_W       = 4;
  localparam int WORD_W    = 32;
  localparam int NUM_RATES = 5;
  localparam int LOW_W     = 26;  // field span owned by the sequencer

  typedef struct packed {
    logic [P_W-1:0] p;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } pll_div_t;

  typedef struct packed {
    logic [15:0]       rate_mhz;
    pll_div_t          div;
    logic [WORD_W-1:0] ext;
  } pll_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTRL,
    S_WR_OFF,
    S_WR_EXT,
    S_SETTLE,
    S_WR_ON,
    S_POLL
  } seq_state_e;

  function automatic pll_entry_t mk_entry(input int rate, input int m, input int n,
                                          input int p, input int ext);
    pll_entry_t e;
    e.rate_mhz = 16'(rate);
    e.div.m    = M_W'(m);
    e.div.n    = N_W'(n);
    e.div.p    = P_W'(p);
    e.ext      = WORD_W'(ext);
    return e;
  endfunction

  function automatic pll_entry_t rate_entry(input int idx);
    case (idx)
      0:       return mk_entry(400,  95,  2, 1,  'h31);
      1:       return mk_entry(200,  127, 0, 15, 'h3F);
      2:       return mk_entry(334,  667, 4, 9,  'h14D);
      3:       return mk_entry(1000, 119, 2, 0,  'h3D);
      default: return mk_entry(50,   95,  2, 15, 'h31);
    endcase
  endfunction

  // control word: [25] reset, [24] bypass, [23] power-off, [22:0] dividers
  function automatic logic [WORD_W-1:0] ctrl_word(input logic [WORD_W-1:0] old_w,
                                                  input pll_div_t div, input logic hold);
    logic [LOW_W-1:0] low;
    low = {hold, 1'b0, hold, div};
    return {old_w[WORD_W-1:LOW_W], low};
  endfunction

endpackage

// File: rtl/pll_rate_lut.sv
module pll_rate_lut
  import pll_seq_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o,
  output pll_div_t          div_o,
  output logic [WORD_W-1:0] ext_o
);

  logic [NUM_RATES-1:0] match;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_cmp
    localparam pll_entry_t ENT = rate_entry(i);
    assign match[i] = (32'(rate_i) == 32'(ENT.rate_mhz));
  end

  always_comb begin
    pll_entry_t e;
    e     = '0;
    hit_o = 1'b0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        e     = rate_entry(i);
      end
    end
    div_o = e.div;
    ext_o = e.ext;
  end

  AST_LUT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)) else $error("AST_LUT_ONEHOT"); // R2

endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o) else $error("AST_TMR_HOLD_ZERO"); // R6

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int RATE_W     = 16,
  parameter int CYC_PER_US = 50,
  parameter int SETTLE_US  = 100,
  parameter int LOCK_TMO   = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [RATE_W-1:0] rate_mhz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic              reg_sel_o,
  output logic [31:0]       reg_wdata_o,
  input  logic [31:0]       reg_rdata_i
);

  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int MAX_WAIT   = (SETTLE_CYC > LOCK_TMO) ? SETTLE_CYC : LOCK_TMO;
  localparam int TMR_W      = $clog2(MAX_WAIT + 1);
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_EXT  = 1'b1;

  seq_state_e        state_q, state_d;
  pll_div_t          div_q;
  logic [WORD_W-1:0] ext_q, ctrl_q;
  logic              done_q, err_q, done_d, err_d;
  logic              lut_hit;
  pll_div_t          lut_div;
  logic [WORD_W-1:0] lut_ext;
  logic              settle_load, settle_zero, tmo_load, tmo_zero;

  pll_rate_lut #(.RATE_W(RATE_W)) u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_mhz_i),
    .hit_o  (lut_hit),
    .div_o  (lut_div),
    .ext_o  (lut_ext)
  );

  pll_wait_timer #(.CNT_W(TMR_W)) u_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (settle_load),
    .load_val_i (TMR_W'(SETTLE_CYC - 1)),
    .zero_o     (settle_zero)
  );

  pll_wait_timer #(.CNT_W(TMR_W)) u_lock_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmo_load),
    .load_val_i (TMR_W'(LOCK_TMO - 1)),
    .zero_o     (tmo_zero)
  );

  assign settle_load = (state_q == S_WR_EXT);
  assign tmo_load    = (state_q == S_WR_ON);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        if (lut_hit) state_d = S_RD_CTRL;
        else         err_d   = 1'b1;
      end
      S_RD_CTRL: state_d = S_WR_OFF;
      S_WR_OFF:  state_d = S_WR_EXT;
      S_WR_EXT:  state_d = S_SETTLE;
      S_SETTLE:  if (settle_zero) state_d = S_WR_ON;
      S_WR_ON:   state_d = S_POLL;
      S_POLL: begin
        if (reg_rdata_i[31]) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else if (tmo_zero) begin
          state_d = S_IDLE;
          err_d   = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      div_q   <= '0;
      ext_q   <= '0;
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (state_q == S_IDLE && req_i && lut_hit) begin
        div_q <= lut_div;
        ext_q <= lut_ext;
      end
      if (state_q == S_RD_CTRL) ctrl_q <= reg_rdata_i;
    end
  end

  always_comb begin
    reg_wr_o    = 1'b0;
    reg_rd_o    = 1'b0;
    reg_sel_o   = SEL_CTRL;
    reg_wdata_o = '0;
    unique case (state_q)
      S_RD_CTRL: reg_rd_o = 1'b1;
      S_WR_OFF: begin
        reg_wr_o    = 1'b1;
        reg_wdata_o = ctrl_word(ctrl_q, div_q, 1'b1);
      end
      S_WR_EXT: begin
        reg_wr_o    = 1'b1;
        reg_sel_o   = SEL_EXT;
        reg_wdata_o = ext_q;
      end
      S_WR_ON: begin
        reg_wr_o    = 1'b1;
        reg_wdata_o = ctrl_word(ctrl_q, div_q, 1'b0);
      end
      S_POLL: begin
        reg_rd_o  = 1'b1;
        reg_sel_o = SEL_EXT;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_EXT_AFTER_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_sel_o) |-> $past(reg_wr_o && !reg_sel_o)) else $error("AST_EXT_AFTER_CTRL"); // R5
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(reg_rd_o && reg_sel_o && reg_rdata_i[31])) else $error("AST_DONE_AFTER_LOCK"); // R7
  AST_BUSY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i)) else $error("AST_BUSY_ON_REQ"); // R9
  AST_ERR_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || done_o) |-> !busy_o) else $error("AST_ERR_NOT_BUSY"); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)) else $error("AST_DONE_ERR_EXCL"); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("AST_DONE_PULSE"); // R10
  AST_WR_RD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o)) else $error("AST_WR_RD_EXCL"); // R4

endmodule

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;

  localparam int RATE_W = 16;
  localparam int CPU    = 50;
  localparam int SUS    = 100;
  localparam int TMO    = 2000;
  localparam int SCYC   = CPU * SUS;
  localparam logic [31:0] INIT_CTRL = 32'hB6AB_CDEF;  // upper 6 bits 101101

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [RATE_W-1:0] rate = '0;
  logic busy, done, err, wr, rd, sel;
  logic [31:0] wdata, rdata;

  always #10 clk = ~clk;

  pll_reprog_seq #(.RATE_W(RATE_W), .CYC_PER_US(CPU), .SETTLE_US(SUS), .LOCK_TMO(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rate_mhz_i(rate),
    .busy_o(busy), .done_o(done), .err_o(err),
    .reg_wr_o(wr), .reg_rd_o(rd), .reg_sel_o(sel),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] ctrl_m, ext_m;
  logic lock_f;
  int lock_cnt, lock_delay;
  int n_wr, n_done, n_err, done_cyc, err_cyc, busy_seen, busy_at_pulse, rd_early;
  logic [31:0] wr_dat [8];
  logic wr_sel [8];
  int wr_cyc [8];

  assign rdata = sel ? {lock_f, ext_m[30:0]} : ctrl_m;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (busy) busy_seen++;
    if (rd && n_wr == 0) rd_early++;
    if (wr) begin
      if (n_wr < 8) begin
        wr_dat[n_wr] = wdata; wr_sel[n_wr] = sel; wr_cyc[n_wr] = cyc;
      end
      n_wr++;
      if (sel) ext_m = wdata;
      else begin
        ctrl_m = wdata;
        lock_f = 1'b0;
        lock_cnt = (!wdata[23] && !wdata[25]) ? lock_delay : 0;
      end
    end else if (lock_cnt != 0) begin
      lock_cnt--;
      if (lock_cnt == 0) lock_f = 1'b1;
    end
    if (done) begin n_done++; done_cyc = cyc; if (busy) busy_at_pulse++; end
    if (err)  begin n_err++;  err_cyc  = cyc; if (busy) busy_at_pulse++; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_wr = 0; n_done = 0; n_err = 0; busy_seen = 0; busy_at_pulse = 0; rd_early = 0;
    done_cyc = 0; err_cyc = 0;
    ctrl_m = INIT_CTRL; ext_m = '0; lock_f = 1'b0; lock_cnt = 0;
  endtask

  task automatic issue(input int r, output int req_cyc);
    @(negedge clk);
    req = 1'b1; rate = RATE_W'(r); req_cyc = cyc;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n;
    n = 0;
    while (n_done + n_err == 0 && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, {tag, " sequence ended"}, n, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !wr && !rd, "R1 outputs idle after reset",
        {busy, done, err, wr, rd}, 0);
  endtask

  task automatic t_rate(input int r, input int m, input int n, input int p,
                        input logic [31:0] ext, input int ldly);
    int rc;
    logic [31:0] w_off, w_on;
    clear_logs();
    lock_delay = ldly;
    issue(r, rc);
    wait_end("R7");
    w_off = {INIT_CTRL[31:26], 3'b101, 4'(p), 6'(n), 13'(m)};
    w_on  = {INIT_CTRL[31:26], 3'b000, 4'(p), 6'(n), 13'(m)};
    chk(n_wr == 3, "R2 three writes", n_wr, 3);
    chk(wr_sel[0] == 1'b0 && wr_dat[0] == w_off, "R4 first control write", wr_dat[0], w_off);
    chk(wr_cyc[0] - rc == 2, "R4 first write timing", wr_cyc[0] - rc, 2);
    chk(rd_early == 1, "R4 one control read before writes", rd_early, 1);
    chk(wr_sel[1] == 1'b1 && wr_dat[1] == ext, "R2 R5 ext write value", wr_dat[1], ext);
    chk(wr_cyc[1] - wr_cyc[0] == 1, "R5 ext write follows", wr_cyc[1] - wr_cyc[0], 1);
    chk(wr_sel[2] == 1'b0 && wr_dat[2] == w_on, "R6 release write", wr_dat[2], w_on);
    chk(wr_cyc[2] - wr_cyc[1] == SCYC + 1, "R6 settle gap", wr_cyc[2] - wr_cyc[1], SCYC + 1);
    chk(n_done == 1 && n_err == 0, "R7 R10 single done", n_done * 16 + n_err, 16);
    chk(done_cyc - wr_cyc[2] == ldly + 1, "R7 done latency", done_cyc - wr_cyc[2], ldly + 1);
    chk(busy_at_pulse == 0 && busy_seen == done_cyc - rc - 1, "R9 busy window",
        busy_seen, done_cyc - rc - 1);
  endtask

  task automatic t_miss();
    int rc;
    clear_logs();
    lock_delay = 3;
    issue(100, rc);
    wait_end("R3");
    chk(n_wr == 0 && rd_early == 0, "R3 no register access", n_wr + rd_early, 0);
    chk(n_err == 1 && err_cyc == rc + 1, "R3 error pulse timing", err_cyc - rc, 1);
    chk(busy_seen == 0 && n_done == 0, "R3 never busy", busy_seen, 0);
  endtask

  task automatic t_timeout();
    int rc;
    clear_logs();
    lock_delay = 100000;
    issue(200, rc);
    wait_end("R8");
    chk(n_wr == 3, "R8 writes before timeout", n_wr, 3);
    chk(n_err == 1 && n_done == 0, "R8 R10 error only", n_err * 16 + n_done, 16);
    chk(err_cyc - wr_cyc[2] == TMO + 1, "R8 timeout latency", err_cyc - wr_cyc[2], TMO + 1);
    chk(busy_at_pulse == 0, "R9 not busy at error", busy_at_pulse, 0);
  endtask

  task automatic t_ignore_busy();
    int rc, rc2;
    clear_logs();
    lock_delay = 6;
    issue(400, rc);
    repeat (3) @(negedge clk);
    issue(1000, rc2);
    repeat (10) @(negedge clk);
    issue(77, rc2);
    wait_end("R9");
    chk(n_wr == 3, "R9 no extra writes", n_wr, 3);
    chk(wr_dat[0][12:0] == 13'd95 && wr_dat[1] == 32'h31, "R9 dividers unchanged",
        wr_dat[0][12:0], 95);
    chk(n_done == 1 && n_err == 0, "R9 ignored requests add no pulse", n_done * 16 + n_err, 16);
  endtask

  initial begin
    clear_logs();
    lock_delay = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rate(400,  95,  2, 1,  32'h31,  5);
    t_rate(200,  127, 0, 15, 32'h3F,  1);
    t_rate(334,  667, 4, 9,  32'h14D, 40);
    t_rate(1000, 119, 2, 0,  32'h3D,  TMO - 1);
    t_rate(50,   95,  2, 15, 32'h31,  12);
    t_miss();
    t_timeout();
    t_ignore_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule